// File: doc/BRIEF.md
# Length-Checked SPI Register Target

This block is the peripheral side of a four-wire SPI link that gives a host access to a small bank of byte-wide registers. A fast system clock oversamples the SPI clock, data-in and active-low chip select through two-flop synchronizers. The block then finds the SPI clock edges in its own clock domain, so an SPI clock period as short as 100 ns is resolved. Shifting is MSB first in SPI mode 1: data-in is taken on the falling SPI clock edge, and data-out moves on the rising edge.

Each frame is one command byte followed by one data byte. In the command byte, bit 7 is reserved and its value is ignored, bit 6 selects read (1) or write (0), and bits 5:0 give the register address. The block counts the falling SPI clock edges inside each chip-select window. On the rising edge of chip select it acts on the frame only if the count is exactly sixteen. Any other count, zero included, discards the frame and sets a sticky clock-fault flag. The flag can be read in the status register, but it never reaches the external active-low fault pin. That pin reflects only the fault input from the rest of the chip.

Top module: `spi_frame_regs`

## Requirements
- R1: After reset, the status register reads 0x01 (bit 0 = SPI OK set, bit 1 = clock fault clear), all data registers read 0x00, and fault_n_o is high while ext_fault_i is low.
- R2: A frame of exactly 16 SPI clocks with command bit 6 = 0 writes the data byte (frame bits 7:0) into the register addressed by command bits 5:0 when chip select rises. Both bytes are MSB first and sampled on the falling SPI clock edge.
- R3: During any frame, sdo_o sends the status byte in the first eight bit slots and the addressed register in the next eight, MSB first, updated after each rising SPI clock edge.
- R4: A frame with fewer than 16 SPI clocks, zero included, sets the clock fault (status 0x02) and leaves every register unchanged.
- R5: A frame with more than 16 SPI clocks sets the clock fault and leaves every register unchanged. This holds for 32 and 48 clocks, because the edge counter saturates and does not wrap.
- R6: The clock fault stays set through any number of later frames. Only a valid 16-clock write of a byte with bit 0 = 1 to address 1 clears it. A clearing write of the wrong length, or one with bit 0 = 0, leaves it set.
- R7: fault_n_o equals the inverse of ext_fault_i and is never driven low by the clock fault.
- R8: Addresses 2 to REG_COUNT-1 are read/write. Address 0 (status) ignores writes. Address 1 (control) reads 0x00. Addresses at or above REG_COUNT ignore writes and read 0x00.
- R9: sdo_o is high-impedance whenever cs_n_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least four times the SPI clock rate |
| rst_n_i | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | SPI clock, idles low |
| sdi_i | input | 1 | SPI data from the host |
| cs_n_i | input | 1 | Active-low chip select |
| ext_fault_i | input | 1 | Fault flag from other chip logic |
| sdo_o | output | 1 | SPI data to the host, high-impedance while deselected |
| fault_n_o | output | 1 | Active-low external fault pin |

## Verification
The bench targets frames of the wrong length that would look valid to a design that only checks the shift register.

- A 32-clock frame whose last 16 bits form a legal write would commit that write in a design that keeps the final shift contents.
- A 48-clock frame would be accepted by a design whose 5-bit counter wraps to 16.
- A 17-clock clear command would erase the fault in a design that decodes the clear before it checks the length.
- An empty chip-select pulse would pass unnoticed in a design that checks the count only when a clock edge arrives.

The bench also raises the clock fault with the external fault input low. This catches any design that routes the clock fault onto the fault pin.

// File: rtl/spi_frame_regs.sv
module spi_frame_regs #(
  parameter int REG_COUNT = 8,
  parameter int CNT_W     = 5
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic sclk_i,
  input  logic sdi_i,
  input  logic cs_n_i,
  input  logic ext_fault_i,
  output logic sdo_o,
  output logic fault_n_o
);
  localparam int IDX_W = $clog2(REG_COUNT);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] CNT_FRAME = CNT_W'(16);
  localparam logic [CNT_W-1:0] CNT_BYTE  = CNT_W'(7);

  logic [2:0] sclk_s, cs_s;
  logic [1:0] sdi_s;
  logic [CNT_W-1:0] bit_cnt;
  logic [14:0] rx;
  logic [7:0]  tx, rd_byte;
  logic        sdo_q, clk_fault;
  logic [REG_COUNT-1:0][7:0] regs;

  always_ff @(posedge clk_i or negedge rst_n_i)
    if (!rst_n_i) begin
      sclk_s <= '0;
      cs_s   <= '1;
      sdi_s  <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk_i};
      cs_s   <= {cs_s[1:0], cs_n_i};
      sdi_s  <= {sdi_s[0], sdi_i};
    end

  wire sclk_rise = sclk_s[1] & ~sclk_s[2];
  wire sclk_fall = ~sclk_s[1] & sclk_s[2];
  wire cs_fall   = ~cs_s[1] & cs_s[2];
  wire cs_rise   = cs_s[1] & ~cs_s[2];
  wire active    = ~cs_s[1];

  wire [14:0] rx_next = {rx[13:0], sdi_s[1]};
  wire [7:0]  status  = {6'b0, clk_fault, ~clk_fault};
  wire        frame_ok = cs_rise && (bit_cnt == CNT_FRAME);
  wire        wr_go    = frame_ok && !rx[14];
  wire [5:0]  wr_addr  = rx[13:8];
  wire [5:0]  rd_addr  = rx_next[5:0];

  always_comb begin
    rd_byte = 8'h00;
    if (rd_addr == 6'd0)
      rd_byte = status;
    else if (rd_addr >= 6'd2 && int'(rd_addr) < REG_COUNT)
      rd_byte = regs[rd_addr[IDX_W-1:0]];
  end

  always_ff @(posedge clk_i or negedge rst_n_i)
    if (!rst_n_i) begin
      bit_cnt <= '0;
      rx      <= '0;
      tx      <= '0;
      sdo_q   <= 1'b0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
      tx      <= status;
      sdo_q   <= 1'b0;
    end else if (active) begin
      if (sclk_fall) begin
        rx <= rx_next;
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_BYTE) tx <= rd_byte;
      end
      if (sclk_rise) begin
        sdo_q <= tx[7];
        tx    <= {tx[6:0], 1'b0};
      end
    end

  always_ff @(posedge clk_i or negedge rst_n_i)
    if (!rst_n_i)
      clk_fault <= 1'b0;
    else if (cs_rise) begin
      if (!frame_ok)
        clk_fault <= 1'b1;
      else if (wr_go && wr_addr == 6'd1 && rx[0])
        clk_fault <= 1'b0;
    end

  always_ff @(posedge clk_i or negedge rst_n_i)
    if (!rst_n_i)
      regs <= '0;
    else if (wr_go)
      for (int i = 2; i < REG_COUNT; i++)
        if (wr_addr == 6'(i)) regs[i] <= rx[7:0];

  assign sdo_o     = cs_n_i ? 1'bz : sdo_q;
  assign fault_n_o = ~ext_fault_i;

  assert_regs_need_full_frame_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !$stable(regs) |-> $past(wr_go));

  assert_short_or_long_faults_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (cs_rise && bit_cnt != CNT_FRAME) |=> clk_fault);

  assert_counter_saturates_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (bit_cnt == CNT_MAX && !cs_fall) |=> bit_cnt == CNT_MAX);

  assert_fault_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(clk_fault) |-> $past(frame_ok));

  assert_fault_off_pin_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (clk_fault && !ext_fault_i) |-> fault_n_o);
endmodule

// File: tb/spi_frame_regs_tb_top.sv
module spi_frame_regs_tb_top;
  logic clk = 0, rst_n = 0, sclk = 0, sdi = 0, cs_n = 1, ext_fault = 0;
  wire  sdo, fault_n;
  int   n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  spi_frame_regs dut_i (.clk_i(clk), .rst_n_i(rst_n), .sclk_i(sclk), .sdi_i(sdi),
    .cs_n_i(cs_n), .ext_fault_i(ext_fault), .sdo_o(sdo), .fault_n_o(fault_n));

  typedef struct { string tag; int nb; logic [15:0] exp; } item_t;
  item_t q[$];

  logic [7:0] m_regs [64];
  logic       m_fault = 0;

  function automatic logic [7:0] m_read(logic [5:0] a);
    if (a == 0) return {6'b0, m_fault, ~m_fault};
    if (a >= 2 && a < 8) return m_regs[a];
    return 8'h00;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic frame(string tag, int nbits, logic [63:0] bits);
    item_t it;
    it.tag = tag;
    it.nb  = (nbits < 16) ? nbits : 16;
    it.exp = {m_read(6'd0), m_read(bits[61:56])};
    q.push_back(it);
    cs_n = 0; #50;
    for (int i = 0; i < nbits; i++) begin
      sclk = 1; sdi = bits[63-i]; #50;
      sclk = 0; #50;
    end
    cs_n = 1;
    if (nbits != 16) m_fault = 1;
    else if (!bits[62]) begin
      if (bits[61:56] == 1 && bits[48]) m_fault = 0;
      else if (bits[61:56] >= 2 && bits[61:56] < 8) m_regs[bits[61:56]] = bits[55:48];
    end
    #200;
  endtask

  task automatic f16(string tag, logic [15:0] w);
    frame(tag, 16, {w, 48'h0});
  endtask

  initial forever begin
    logic [15:0] cap;
    int n;
    bit done;
    @(negedge cs_n);
    cap = '0; n = 0; done = 0;
    while (!done) begin
      @(negedge sclk or posedge cs_n);
      if (cs_n) done = 1;
      else begin
        if (n < 16) cap[15-n] = sdo;
        n++;
      end
    end
    if (q.size() != 0) begin
      item_t it;
      logic [15:0] m;
      it = q.pop_front();
      if (it.nb > 0) begin
        m = 16'hFFFF << (16 - it.nb);
        check(it.tag, cap & m, it.exp & m);
      end
    end
  end

  initial begin
    #(200000 * 8);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m_regs[i] = 8'h00;
    #40 rst_n = 1;
    @(negedge clk); #1;
    check("R9 sdo hi-z idle", {15'b0, sdo === 1'bz}, 16'd1);
    check("R1 fault_n high", {15'b0, fault_n}, 16'd1);
    f16("R1 reset status", 16'h4000);
    f16("R1 reset reg5", 16'h4500);
    f16("R2 write reg2", 16'h02A5);
    f16("R2 write reg7", 16'h073C);
    f16("R3 read reg2", 16'h4200);
    f16("R3 read reg7", 16'h4700);
    f16("R8 write addr9", 16'h095A);
    f16("R8 read addr9", 16'h4900);
    f16("R8 write status", 16'h00FF);
    f16("R8 read status", 16'h4000);
    frame("R4 15-clock write", 15, {16'h0211, 48'h0});
    f16("R4 reg2 kept", 16'h4200);
    f16("R6 clear", 16'h0101);
    frame("R4 zero clocks", 0, 64'h0);
    f16("R4 status after empty", 16'h4000);
    f16("R6 clear", 16'h0101);
    frame("R5 32-clock frame", 32, {16'h0211, 16'h0322, 32'h0});
    f16("R5 reg2 kept", 16'h4200);
    f16("R5 reg3 kept", 16'h4300);
    f16("R6 clear", 16'h0101);
    frame("R5 48-clock frame", 48, {16'h0277, 16'h0277, 16'h0277, 16'h0});
    f16("R5 reg2 kept 48", 16'h4200);
    frame("R6 17-clock clear", 17, {16'h0101, 48'h0});
    f16("R6 still set", 16'h4000);
    f16("R6 clear bit0 zero", 16'h0100);
    f16("R6 still set 2", 16'h4000);
    check("R7 pin idle during fault", {15'b0, fault_n}, 16'd1);
    ext_fault = 1; #50;
    check("R7 pin follows input", {15'b0, fault_n}, 16'd0);
    ext_fault = 0; #50;
    f16("R6 valid clear", 16'h0101);
    f16("R6 cleared", 16'h4000);
    f16("R8 ctrl reads zero", 16'h4100);
    check("R9 sdo hi-z end", {15'b0, sdo === 1'bz}, 16'd1);
    #200;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule